// File: doc/BRIEF.md
# ADC Serial Capture Controller

This block runs a 12-bit converter that has a serial output. It drives the converter's active-low convert-start line and its serial clock, and it collects the result from the converter's data line. A host asks for one of three power levels: normal, partial power-down or full power-down. The host raises a request together with that level and a coding choice. In normal mode every accepted request gives one captured sample, flagged by a single-cycle valid strobe. The sample is coded either as unsigned binary or as two's complement.

The converter picks its power level from the point in the clock frame at which convert-start goes back high. A full 16-edge frame with convert-start released late keeps it converting. A short frame with convert-start released after the third edge puts it into a power-down level. Two short frames in a row take it into the deeper level. A full-length frame wakes it again. The controller plans this chain of frames itself from the present level and the requested level. After a wake from the deepest level it waits a fixed recovery time before the next frame.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, `conv_n_o` is high, `sclk_o` is low, `busy_o` and `sample_valid_o` are low, `sample_o` is zero and `pwr_mode_o` is 0 (normal).
- R2: A conversion frame proceeds as follows. `conv_n_o` falls on the second clock edge after the edge that accepts the request. `sclk_o` then makes 16 rising edges, with each high phase and each low phase lasting SCLK_HALF system cycles. `conv_n_o` rises at the falling edge after the 15th rising edge. The frame ends at the falling edge after the 16th rising edge, and `sclk_o` then stays low.
- R3: Data bits are sampled on `sdata_i` at rising edges 5 to 16, MSB first; the three leading zeros are discarded. `sample_valid_o` pulses for one cycle on the clock edge after the frame ends, and `busy_o` falls on that same edge.
- R4: If `req_bipolar_i` was 1 at acceptance, `sample_o` is the captured code with its MSB inverted (offset binary turned into two's complement). If it was 0, `sample_o` is the captured code unchanged.
- R5: `req_mode_i` and `pwr_mode_o` use the same encoding: 0 normal, 1 partial power-down, 2 full power-down. A request for 1 made from normal issues a short frame. In a short frame `conv_n_o` falls, `sclk_o` makes 3 rising edges, and `conv_n_o` rises at the falling edge after the 3rd. `pwr_mode_o` becomes 1 and no sample is produced.
- R6: A request for 2 made from normal issues two short frames back to back. `pwr_mode_o` reads 1 after the first frame and 2 after the second. `pwr_mode_o` never enters 2 from any value other than 1.
- R7: A request for 0 made from a power-down level first issues a full-length wake frame and discards its data. `pwr_mode_o` then returns to 0 and a conversion frame follows that delivers a sample.
- R8: After a wake frame taken from level 2, the next frame starts exactly RECOV_CYC system cycles later than it would after a wake from level 1.
- R9: While no frame is running, and in particular in either power-down level, `sclk_o` holds a static low level.
- R10: `busy_o` rises on the edge that accepts a request. A request raised while `busy_o` is high is ignored and changes neither the requested level nor the sequence of frames.
- R11: A request for the power-down level already in force issues no frame. `busy_o` is then high for exactly one cycle.
- R12: If `req_i` stays high, the next request is accepted on the edge after `sample_valid_o`. The next frame's `conv_n_o` falls three edges after the edge that raised `sample_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe, taken only while idle |
| req_mode_i | input | 2 | Requested power level (0 normal, 1 partial, 2 full) |
| req_bipolar_i | input | 1 | Selects two's-complement output coding |
| busy_o | output | 1 | A request is being served |
| conv_n_o | output | 1 | Active-low convert-start to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_i | input | 1 | Serial data from the converter |
| sample_o | output | DATA_W | Last captured, formatted sample |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |
| pwr_mode_o | output | 2 | Power level the converter is in |

## Verification
The reference model steps through every frame edge by edge. A shift window off by one edge, in either direction, shows up at once as a wrong sample. Releasing convert-start one edge early or late shows up as a mismatch on `conv_n_o`. The bench runs a full power-down entry and a recovery. A design that skips the second short frame would report the wrong power level. A design that forgets the recovery wait, or applies it after a partial wake, would start its next frame at the wrong cycle. Requests raised mid-frame and requests held high continuously catch designs that latch a new level while busy or that lose the cycle between back-to-back samples.

// File: rtl/adc_cap_pkg.sv
// Package: shared types for the serial converter capture controller.
// Assumes the power-level encoding is also used on the request port.
package adc_cap_pkg;

    typedef enum logic [1:0] {
        PWR_NORMAL  = 2'd0,
        PWR_PARTIAL = 2'd1,
        PWR_FULL    = 2'd2
    } pwr_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_DECIDE,
        SEQ_FRAME,
        SEQ_RECOVER
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_CONVERT,
        ACT_SLEEP,
        ACT_WAKE
    } frame_act_e;

    // Map a raw request code onto a power level; unknown codes mean normal.
    function automatic pwr_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd1:    return PWR_PARTIAL;
            2'd2:    return PWR_FULL;
            default: return PWR_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/adc_frame_engine.sv
// Module: adc_frame_engine
// Runs one converter frame: it drops convert-start, toggles the serial clock
// every SCLK_HALF system cycles, and counts rising edges.
// A long frame makes LEAD_ZEROS+DATA_W+1 rising edges, releases convert-start
// after the second to last of them, and shifts data in from edge LEAD_ZEROS+2 on.
// A short frame makes SLEEP_EDGES rising edges and releases convert-start after the last.
// Assumes start_i is raised only while the engine is idle.
module adc_frame_engine #(
    parameter int SCLK_HALF   = 2,
    parameter int DATA_W      = 12,
    parameter int LEAD_ZEROS  = 3,
    parameter int SLEEP_EDGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              short_i,
    input  logic              sdata_i,
    output logic              conv_n_o,
    output logic              sclk_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int FRAME_EDGES = LEAD_ZEROS + DATA_W + 1;
    localparam int FIRST_CAP   = LEAD_ZEROS + 2;
    localparam int EW          = $clog2(FRAME_EDGES + 1);
    localparam int DIV_W       = $clog2(SCLK_HALF + 1);

    logic              active_q;
    logic              short_q;
    logic              sclk_q;
    logic              conv_n_q;
    logic              done_q;
    logic [DIV_W-1:0]  div_q;
    logic [EW-1:0]     edge_q;
    logic [DATA_W-1:0] shreg_q;

    logic              tick;
    logic [EW-1:0]     next_edge;
    logic [EW-1:0]     last_edge;
    logic [EW-1:0]     release_edge;

    // Half-period strobe and frame geometry for the current frame kind.
    always_comb begin
        tick         = active_q && (div_q == DIV_W'(SCLK_HALF - 1));
        next_edge    = edge_q + EW'(1);
        last_edge    = short_q ? EW'(SLEEP_EDGES) : EW'(FRAME_EDGES);
        release_edge = short_q ? EW'(SLEEP_EDGES) : EW'(FRAME_EDGES - 1);
    end

    // Frame sequencing: clock toggling, edge counting, data shifting, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            short_q  <= 1'b0;
            sclk_q   <= 1'b0;
            conv_n_q <= 1'b1;
            done_q   <= 1'b0;
            div_q    <= '0;
            edge_q   <= '0;
            shreg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !active_q) begin
                active_q <= 1'b1;
                short_q  <= short_i;
                conv_n_q <= 1'b0;
                sclk_q   <= 1'b0;
                div_q    <= '0;
                edge_q   <= '0;
            end else if (active_q) begin
                if (tick) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        edge_q <= next_edge;
                        if (!short_q && next_edge >= EW'(FIRST_CAP))
                            shreg_q <= {shreg_q[DATA_W-2:0], sdata_i};
                    end else begin
                        sclk_q <= 1'b0;
                        if (edge_q == release_edge)
                            conv_n_q <= 1'b1;
                        if (edge_q == last_edge) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end

    assign conv_n_o = conv_n_q;
    assign sclk_o   = sclk_q;
    assign done_o   = done_q;
    assign data_o   = shreg_q;

    // R2: the edge count never runs past the length of a long frame.
    a_r2_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        edge_q <= EW'(FRAME_EDGES));

    // R2: convert-start only falls when a frame was started.
    a_r2_fall_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n_q) |-> $past(start_i));

    // R2: in a long frame, convert-start stays low until the release edge.
    a_r2_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !short_q && edge_q < EW'(FRAME_EDGES - 1)) |-> !conv_n_q);

    // R9: with no frame running, the serial clock does not move.
    a_r9_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !start_i) |=> $stable(sclk_q));

endmodule

// File: rtl/adc_recovery_timer.sv
// Module: adc_recovery_timer
// Counts a fixed wait of RECOV_CYC system cycles once start_i pulses.
// expired_o is high during the last cycle of the wait.
// Assumes RECOV_CYC >= 1 and that start_i does not repeat while counting.
module adc_recovery_timer #(
    parameter int RECOV_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);

    localparam int CW = $clog2(RECOV_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [CW-1:0] elapsed_q;

    // Countdown from the loaded wait length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= CW'(RECOV_CYC - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired_o = run_q && (cnt_q == '0);

    // Independent up-counter used only to check the length of the wait.
    always_ff @(posedge clk) begin
        if (!rst_n)        elapsed_q <= '0;
        else if (start_i)  elapsed_q <= '0;
        else if (run_q)    elapsed_q <= elapsed_q + CW'(1);
    end

    // R8: the wait never ends before the full recovery length has passed.
    a_r8_full_wait: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> (elapsed_q == CW'(RECOV_CYC - 1)));

    // R8: expiry is a single-cycle event.
    a_r8_expire_once: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !start_i) |=> !expired_o);

endmodule

// File: rtl/adc_code_fmt.sv
// Module: adc_code_fmt
// Turns a captured offset-binary code into two's complement when asked,
// by inverting the MSB; otherwise passes the code through unchanged.
// Purely combinational.
module adc_code_fmt #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic              bipolar_i,
    output logic [DATA_W-1:0] code_o
);

    // Optional sign conversion of the sample.
    always_comb begin
        code_o = raw_i;
        if (bipolar_i)
            code_o[DATA_W-1] = ~raw_i[DATA_W-1];
    end

endmodule

// File: rtl/adc_frame_ctrl.sv
// Module: adc_frame_ctrl (top)
// Serves host requests for a power level by chaining converter frames:
// conversion frames in normal mode, short frames to step down a level, and a
// full-length wake frame to step back up. After waking from the deepest
// level it waits for the reference to recover.
// Assumes the converter follows the frame rules built into adc_frame_engine.
module adc_frame_ctrl
    import adc_cap_pkg::*;
#(
    parameter int SCLK_HALF   = 2,
    parameter int DATA_W      = 12,
    parameter int LEAD_ZEROS  = 3,
    parameter int SLEEP_EDGES = 3,
    parameter int RECOV_CYC   = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        req_mode_i,
    input  logic              req_bipolar_i,
    output logic              busy_o,
    output logic              conv_n_o,
    output logic              sclk_o,
    input  logic              sdata_i,
    output logic [DATA_W-1:0] sample_o,
    output logic              sample_valid_o,
    output logic [1:0]        pwr_mode_o
);

    seq_state_e        seq_q;
    pwr_mode_e         cur_q;
    pwr_mode_e         tgt_q;
    frame_act_e        act_q;
    frame_act_e        dec_act;
    logic              dec_done;
    logic              bip_q;
    logic              busy_q;
    logic              valid_q;
    logic              eng_start_q;
    logic              eng_short_q;
    logic [DATA_W-1:0] sample_q;

    logic              eng_done;
    logic [DATA_W-1:0] eng_data;
    logic [DATA_W-1:0] fmt_code;
    logic              tmr_start;
    logic              tmr_expired;

    adc_frame_engine #(
        .SCLK_HALF  (SCLK_HALF),
        .DATA_W     (DATA_W),
        .LEAD_ZEROS (LEAD_ZEROS),
        .SLEEP_EDGES(SLEEP_EDGES)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (eng_start_q),
        .short_i  (eng_short_q),
        .sdata_i  (sdata_i),
        .conv_n_o (conv_n_o),
        .sclk_o   (sclk_o),
        .done_o   (eng_done),
        .data_o   (eng_data)
    );

    adc_recovery_timer #(
        .RECOV_CYC(RECOV_CYC)
    ) u_recover (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (tmr_start),
        .expired_o (tmr_expired)
    );

    adc_code_fmt #(
        .DATA_W(DATA_W)
    ) u_fmt (
        .raw_i     (eng_data),
        .bipolar_i (bip_q),
        .code_o    (fmt_code)
    );

    // Pick the next step from the present level and the requested one.
    always_comb begin
        dec_done = (cur_q == tgt_q) && (tgt_q != PWR_NORMAL);
        if (cur_q == tgt_q)
            dec_act = ACT_CONVERT;
        else if (cur_q == PWR_NORMAL || (cur_q == PWR_PARTIAL && tgt_q == PWR_FULL))
            dec_act = ACT_SLEEP;
        else
            dec_act = ACT_WAKE;
    end

    // Recovery starts when a wake frame from the deepest level completes.
    assign tmr_start = (seq_q == SEQ_FRAME) && eng_done &&
                       (act_q == ACT_WAKE) && (cur_q == PWR_FULL);

    // Request sequencer: accept, decide, run a frame, optionally recover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= SEQ_IDLE;
            cur_q       <= PWR_NORMAL;
            tgt_q       <= PWR_NORMAL;
            act_q       <= ACT_CONVERT;
            bip_q       <= 1'b0;
            busy_q      <= 1'b0;
            valid_q     <= 1'b0;
            eng_start_q <= 1'b0;
            eng_short_q <= 1'b0;
            sample_q    <= '0;
        end else begin
            valid_q     <= 1'b0;
            eng_start_q <= 1'b0;
            case (seq_q)
                SEQ_IDLE: begin
                    if (req_i) begin
                        tgt_q  <= decode_mode(req_mode_i);
                        bip_q  <= req_bipolar_i;
                        busy_q <= 1'b1;
                        seq_q  <= SEQ_DECIDE;
                    end
                end
                SEQ_DECIDE: begin
                    if (dec_done) begin
                        busy_q <= 1'b0;
                        seq_q  <= SEQ_IDLE;
                    end else begin
                        act_q       <= dec_act;
                        eng_start_q <= 1'b1;
                        eng_short_q <= (dec_act == ACT_SLEEP);
                        seq_q       <= SEQ_FRAME;
                    end
                end
                SEQ_FRAME: begin
                    if (eng_done) begin
                        case (act_q)
                            ACT_CONVERT: begin
                                sample_q <= fmt_code;
                                valid_q  <= 1'b1;
                                busy_q   <= 1'b0;
                                seq_q    <= SEQ_IDLE;
                            end
                            ACT_SLEEP: begin
                                cur_q <= (cur_q == PWR_PARTIAL) ? PWR_FULL : PWR_PARTIAL;
                                seq_q <= SEQ_DECIDE;
                            end
                            default: begin
                                cur_q <= PWR_NORMAL;
                                seq_q <= (cur_q == PWR_FULL) ? SEQ_RECOVER : SEQ_DECIDE;
                            end
                        endcase
                    end
                end
                default: begin
                    if (tmr_expired) seq_q <= SEQ_DECIDE;
                end
            endcase
        end
    end

    assign busy_o         = busy_q;
    assign sample_o       = sample_q;
    assign sample_valid_o = valid_q;
    assign pwr_mode_o     = cur_q;

    // R3: a new sample is strobed only right after a frame completes.
    a_r3_valid_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(eng_done));

    // R3: the valid strobe lasts one cycle.
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R6: the deepest level is entered only from partial power-down.
    a_r6_full_via_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == PWR_FULL && $past(cur_q) != PWR_FULL) |-> ($past(cur_q) == PWR_PARTIAL));

    // R9: the serial clock is static while parked in a power-down level.
    a_r9_parked_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && cur_q != PWR_NORMAL) |=> $stable(sclk_o));

    // R10: a request made while busy leaves the requested level alone.
    a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && busy_q) |=> (tgt_q == $past(tgt_q)));

endmodule

// File: tb/adc_frame_ctrl_test.sv
// Bench for adc_frame_ctrl. A behavioural reference model predicts every
// output cycle by cycle and is compared on each falling clock edge.
module adc_frame_ctrl_test;

    localparam int HALF = 2;
    localparam int W    = 12;
    localparam int RCY  = 50;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       req   = 1'b0;
    logic [1:0] mode  = 2'd0;
    logic       bip   = 1'b0;
    logic       sdata = 1'b0;

    wire         busy, conv_n, sclk, valid;
    wire [W-1:0] sample;
    wire [1:0]   pmode;

    adc_frame_ctrl #(
        .SCLK_HALF(HALF), .DATA_W(W), .LEAD_ZEROS(3), .SLEEP_EDGES(3), .RECOV_CYC(RCY)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_mode_i(mode),
        .req_bipolar_i(bip), .busy_o(busy), .conv_n_o(conv_n), .sclk_o(sclk),
        .sdata_i(sdata), .sample_o(sample), .sample_valid_o(valid), .pwr_mode_o(pmode)
    );

    int    vectors = 0;
    int    fails   = 0;
    string phase   = "R1 reset";
    bit    started = 1'b0;

    // Converter stand-in: three zeros, then the code MSB first after rising edge 4.
    int adc_val = 0;
    int rcount  = 0;
    always @(negedge conv_n) begin
        rcount = 0;
        sdata  = 1'b0;
    end
    always @(posedge sclk) begin
        rcount = rcount + 1;
        #1;
        if (rcount >= 4 && rcount <= 15) sdata = ((adc_val >> (15 - rcount)) & 1) != 0;
        else                             sdata = 1'b0;
    end

    // Reference model state.
    bit e_conv_n = 1'b1, e_sclk = 1'b0, e_busy = 1'b0, e_valid = 1'b0;
    int e_sample = 0, e_pmode = 0, m_cur = 0, m_tgt = 0;
    bit m_bip = 1'b0;

    task automatic m_wait(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic m_frame(input bit is_short, output int raw);
        raw = 0;
        m_wait(1);
        e_conv_n = 1'b0;
        e_sclk   = 1'b0;
        for (int k = 1; k <= (is_short ? 3 : 16); k++) begin
            m_wait(HALF);
            e_sclk = 1'b1;
            if (!is_short && k >= 5) raw = ((raw << 1) | int'(sdata)) & 12'hFFF;
            m_wait(HALF);
            e_sclk = 1'b0;
            if ((is_short && k == 3) || (!is_short && k == 15)) e_conv_n = 1'b1;
        end
    endtask

    task automatic m_run();
        int raw;
        forever begin
            m_wait(1);
            if (m_cur == m_tgt && m_tgt != 0) begin
                e_busy = 1'b0;
                return;
            end
            if (m_cur == m_tgt) begin
                m_frame(1'b0, raw);
                m_wait(1);
                e_valid  = 1'b1;
                e_sample = m_bip ? (raw ^ 12'h800) : raw;
                e_busy   = 1'b0;
                return;
            end else if (m_cur == 0 || (m_cur == 1 && m_tgt == 2)) begin
                m_frame(1'b1, raw);
                m_wait(1);
                m_cur   = m_cur + 1;
                e_pmode = m_cur;
            end else begin
                m_frame(1'b0, raw);
                m_wait(1);
                if (m_cur == 2) begin
                    m_cur = 0; e_pmode = 0;
                    m_wait(RCY);
                end else begin
                    m_cur = 0; e_pmode = 0;
                end
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            e_valid = 1'b0;
            if (!rst_n) begin
                e_conv_n = 1'b1; e_sclk = 1'b0; e_busy = 1'b0;
                e_sample = 0; e_pmode = 0; m_cur = 0;
            end else if (req && !e_busy) begin
                m_tgt  = (mode == 2'd2) ? 2 : (mode == 2'd1) ? 1 : 0;
                m_bip  = bip;
                e_busy = 1'b1;
                m_run();
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
        end
    endtask

    initial begin
        @(posedge clk);
        started = 1'b1;
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk(conv_n == e_conv_n, "R2 conv_n", int'(conv_n), int'(e_conv_n));
            chk(sclk == e_sclk, "R9 sclk", int'(sclk), int'(e_sclk));
            chk(busy == e_busy, "R10 busy", int'(busy), int'(e_busy));
            chk(valid == e_valid, "R3 valid", int'(valid), int'(e_valid));
            chk(int'(sample) == e_sample, "R4 sample", int'(sample), e_sample);
            chk(int'(pmode) == e_pmode, "R6 pwr_mode", int'(pmode), e_pmode);
        end
    end

    task automatic issue(input logic [1:0] m, input logic b);
        @(negedge clk);
        req = 1'b1; mode = m; bip = b;
        @(negedge clk);
        req = 1'b0;
        while (e_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog [%s] actual=running expected=done", phase);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle levels straight after reset
        chk(conv_n == 1'b1, "R1 conv_n", int'(conv_n), 1);
        chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
        chk(busy == 1'b0 && valid == 1'b0, "R1 busy/valid", int'({busy, valid}), 0);
        chk(pmode == 2'd0, "R1 pwr_mode", int'(pmode), 0);

        phase = "R2 R3 unipolar"; adc_val = 12'hA5C; issue(2'd0, 1'b0);
        chk(int'(sample) == 12'hA5C, "R3 sample", int'(sample), 12'hA5C);

        phase = "R4 bipolar"; adc_val = 12'h123; issue(2'd0, 1'b1);
        chk(int'(sample) == 12'h923, "R4 sample", int'(sample), 12'h923);
        adc_val = 12'hFFF; issue(2'd0, 1'b0);
        adc_val = 12'h000; issue(2'd0, 1'b1);
        chk(int'(sample) == 12'h800, "R4 zero code", int'(sample), 12'h800);

        // R10: a partial-power-down request mid-frame must not take effect
        phase = "R10 ignored"; adc_val = 12'h5A5;
        @(negedge clk); req = 1'b1; mode = 2'd0; bip = 1'b0;
        @(negedge clk); req = 1'b0;
        repeat (10) @(negedge clk);
        req = 1'b1; mode = 2'd1;
        @(negedge clk); req = 1'b0;
        while (e_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(pmode == 2'd0, "R10 level kept", int'(pmode), 0);

        phase = "R5 partial"; issue(2'd1, 1'b0);
        chk(pmode == 2'd1, "R5 pwr_mode", int'(pmode), 1);
        phase = "R9 parked"; repeat (40) @(negedge clk);
        phase = "R11 same level"; issue(2'd1, 1'b0);

        phase = "R7 wake"; adc_val = 12'h3C5; issue(2'd0, 1'b0);
        chk(int'(sample) == 12'h3C5, "R7 sample", int'(sample), 12'h3C5);

        phase = "R6 full"; issue(2'd2, 1'b0);
        chk(pmode == 2'd2, "R6 pwr_mode", int'(pmode), 2);

        phase = "R8 recovery"; adc_val = 12'h801; issue(2'd0, 1'b1);
        chk(int'(sample) == 12'h001, "R8 sample", int'(sample), 12'h001);

        // R12: request held high gives back-to-back frames
        phase = "R12 stream"; adc_val = 12'h6B2;
        @(negedge clk); req = 1'b1; mode = 2'd0; bip = 1'b0;
        begin
            int nv = 0;
            while (nv < 3) begin
                @(negedge clk);
                if (valid) nv++;
            end
        end
        req = 1'b0;
        while (e_busy) @(negedge clk);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule